// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a circular list of transmit descriptors kept in memory and turns each one into a segment request for the transmit path. Every descriptor takes 16 bytes of address space. Its 64-bit control word holds an ownership flag, a segment length, flags that mark the first and last segment of a frame, an end-of-ring marker and two event-request bits. A walk starts when software pulses the poll-demand strobe or when the periodic poll tick arrives. The walk continues from descriptor to descriptor until the fetcher reads a control word that software still owns.

For each descriptor that the hardware owns, the fetcher presents the segment until the transmit path accepts it. If that segment is the last one of a frame, the fetcher also waits for the wire-completion strobe. It then writes the control word back with ownership returned to software and the collision status filled in. Descriptor memory sits behind a single synchronous port with one-cycle read latency. Events leave the block as single-cycle pulses.

Top module: `tx_desc_fetcher`

## Requirements
- R1: After reset the fetcher is idle. There is no memory access, no segment request and no event pulse, and the ring pointer equals the ring base, which is address 0.
- R2: A poll-demand or poll-tick pulse seen while idle with DMA enabled issues a read of the control word at the ring pointer on the second clock edge. A poll is ignored while DMA is disabled or while a descriptor is in progress.
- R3: A control word read with bit 31 equal to 0 (software owned) makes no segment request and no writeback. It raises a one-cycle out-of-buffer pulse and returns the fetcher to idle. The pointer is left unchanged, so the next poll reads the same descriptor again.
- R4: A control word with bit 31 equal to 1 produces a segment request that carries the length from bits 42:32, the first-segment flag from bit 60 and the last-segment flag from bit 59. The request and its fields stay stable until seg_ready_i is seen high.
- R5: If bit 61 is set, a one-cycle FIFO-load event pulse follows the edge at which the segment is accepted.
- R6: A descriptor whose last-segment flag is clear is written back right after acceptance. A last-segment descriptor is written back only after tx_done_i, and no earlier.
- R7: The writeback goes to the address the word was read from. Bit 31 is cleared, bits 1:0 take tx_col_i as sampled with tx_done_i (0 for a descriptor that is not last), and every other bit, the end-of-ring bit 63 included, is unchanged.
- R8: A one-cycle transmit-done event pulse follows the writeback of a descriptor that has both bit 62 and the last-segment flag set.
- R9: After a writeback the next control word is read at once, at the previous address plus 16, or at the ring base if bit 63 of the descriptor just written back was set.
- R10: A base write loads both the base and the pointer with base_addr_i with its low 4 bits forced to zero. In the same cycle it takes priority over the advance that follows a writeback.
- R11: Dropping dma_en_i abandons the descriptor in progress without a writeback, removes any segment request, and returns the pointer to the ring base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dma_en_i | input | 1 | Transmit DMA enable |
| base_wr_i | input | 1 | Ring base write strobe |
| base_addr_i | input | AW | Ring base address |
| poll_demand_i | input | 1 | Software poll-demand strobe |
| poll_tick_i | input | 1 | Periodic poll tick |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory byte address of the control word |
| mem_wdata_o | output | 64 | Writeback control word |
| mem_rdata_i | input | 64 | Read data, valid one cycle after a read |
| seg_valid_o | output | 1 | Segment request |
| seg_len_o | output | LW | Segment length in bytes |
| seg_first_o | output | 1 | First segment of a frame |
| seg_last_o | output | 1 | Last segment of a frame |
| seg_ready_i | input | 1 | Segment loaded into the transmit FIFO |
| tx_done_i | input | 1 | Frame has left on the wire |
| tx_col_i | input | 2 | Collision status for the frame |
| evt_fifo_o | output | 1 | FIFO-load event pulse |
| evt_done_o | output | 1 | Transmit-done event pulse |
| evt_nobuf_o | output | 1 | Out-of-buffer event pulse |

## Verification
The pointer advance that ends a writeback and a software base write can land on the same clock edge. The bench provokes this by asserting the base write during the single writeback cycle that follows tx_done_i. It then requires the next read to come from the new base, and the writeback itself to go to the old descriptor address. The bench also pulses a poll while a segment is pending and confirms that no additional read is issued.

// File: rtl/tx_desc_pkg.sv
package tx_desc_pkg;
  localparam int unsigned CW       = 64;
  localparam int unsigned LEN_W    = 11;
  localparam int unsigned LEN_LSB  = 32;
  localparam int unsigned B_OWN    = 31;
  localparam int unsigned B_EOR    = 63;
  localparam int unsigned B_DIRQ   = 62;
  localparam int unsigned B_FIRQ   = 61;
  localparam int unsigned B_FIRST  = 60;
  localparam int unsigned B_LAST   = 59;
  localparam int unsigned COL_W    = 2;
  localparam int unsigned DESC_B   = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_SEG, ST_WIRE, ST_WBACK
  } fetch_state_e;
endpackage

// File: rtl/tx_ring_ptr.sv
module tx_ring_ptr #(
  parameter int unsigned AW     = 16,
  parameter int unsigned STRIDE = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dma_en_i,
  input  logic          base_wr_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          advance_i,
  input  logic          wrap_i,
  output logic [AW-1:0] ptr_o
);
  localparam int unsigned ALIGN = $clog2(STRIDE);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'((1 << ALIGN) - 1);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);

  logic [AW-1:0] base_q, ptr_q, base_new;

  assign base_new = base_addr_i & ALIGN_MASK;
  assign ptr_o    = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (base_wr_i) base_q <= base_new;
      if (base_wr_i)      ptr_q <= base_new;
      else if (!dma_en_i) ptr_q <= base_q;
      else if (advance_i) ptr_q <= wrap_i ? base_q : ptr_q + STEP;
    end
  end

  p_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i && !wrap_i && dma_en_i && !base_wr_i |=> ptr_q == $past(ptr_q) + STEP);
  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i && wrap_i && dma_en_i && !base_wr_i |=> ptr_q == $past(base_q));
  p_base_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_i |=> ptr_q == ($past(base_addr_i) & ALIGN_MASK));
  p_disable_rewind_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i && !base_wr_i |=> ptr_q == base_q);
endmodule

// File: rtl/tx_desc_wb_fmt.sv
module tx_desc_wb_fmt
  import tx_desc_pkg::*;
(
  input  logic [CW-1:0]    desc_i,
  input  logic [COL_W-1:0] col_i,
  output logic [CW-1:0]    word_o
);
  always_comb begin
    word_o = desc_i;
    word_o[B_OWN] = 1'b0;
    word_o[COL_W-1:0] = col_i;
  end
endmodule

// File: rtl/tx_desc_ctrl.sv
module tx_desc_ctrl
  import tx_desc_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dma_en_i,
  input  logic             poll_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic [CW-1:0]    rdata_i,
  input  logic             seg_ready_i,
  input  logic             tx_done_i,
  input  logic [COL_W-1:0] tx_col_i,
  output logic             rd_o,
  output logic             wr_o,
  output logic [AW-1:0]    addr_o,
  output logic [CW-1:0]    desc_o,
  output logic [COL_W-1:0] col_o,
  output logic             seg_valid_o,
  output logic             advance_o,
  output logic             evt_fifo_o,
  output logic             evt_done_o,
  output logic             evt_nobuf_o
);
  fetch_state_e state_q;
  logic [CW-1:0]    desc_q;
  logic [COL_W-1:0] col_q;
  logic [AW-1:0]    daddr_q;
  logic fifo_q, done_q, nobuf_q;

  assign rd_o        = state_q == ST_FETCH;
  assign wr_o        = state_q == ST_WBACK;
  assign addr_o      = (state_q == ST_WBACK) ? daddr_q : ptr_i;
  assign desc_o      = desc_q;
  assign col_o       = col_q;
  assign seg_valid_o = state_q == ST_SEG;
  assign advance_o   = state_q == ST_WBACK;
  assign evt_fifo_o  = fifo_q;
  assign evt_done_o  = done_q;
  assign evt_nobuf_o = nobuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      col_q   <= '0;
      daddr_q <= '0;
      fifo_q  <= 1'b0;
      done_q  <= 1'b0;
      nobuf_q <= 1'b0;
    end else begin
      fifo_q  <= 1'b0;
      done_q  <= 1'b0;
      nobuf_q <= 1'b0;
      if (!dma_en_i) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE:  if (poll_i) state_q <= ST_FETCH;
          ST_FETCH: begin
            daddr_q <= ptr_i;
            state_q <= ST_CHECK;
          end
          ST_CHECK: begin
            desc_q <= rdata_i;
            col_q  <= '0;
            if (rdata_i[B_OWN]) state_q <= ST_SEG;
            else begin
              nobuf_q <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          ST_SEG: if (seg_ready_i) begin
            fifo_q  <= desc_q[B_FIRQ];
            state_q <= desc_q[B_LAST] ? ST_WIRE : ST_WBACK;
          end
          ST_WIRE: if (tx_done_i) begin
            col_q   <= tx_col_i;
            state_q <= ST_WBACK;
          end
          ST_WBACK: begin
            done_q  <= desc_q[B_DIRQ] & desc_q[B_LAST];
            state_q <= ST_FETCH;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_nobuf_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nobuf_q |-> state_q == ST_IDLE);
  p_seg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && !seg_ready_i && dma_en_i |=> seg_valid_o && $stable(desc_q));
  p_wire_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WIRE && !tx_done_i && dma_en_i |=> state_q == ST_WIRE);
  p_refetch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o && dma_en_i |=> rd_o);
  p_evt_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fifo_q, done_q, nobuf_q}));
endmodule

// File: rtl/tx_desc_fetcher.sv
module tx_desc_fetcher
  import tx_desc_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = LEN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dma_en_i,
  input  logic          base_wr_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          poll_demand_i,
  input  logic          poll_tick_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [63:0]   mem_wdata_o,
  input  logic [63:0]   mem_rdata_i,
  output logic          seg_valid_o,
  output logic [LW-1:0] seg_len_o,
  output logic          seg_first_o,
  output logic          seg_last_o,
  input  logic          seg_ready_i,
  input  logic          tx_done_i,
  input  logic [1:0]    tx_col_i,
  output logic          evt_fifo_o,
  output logic          evt_done_o,
  output logic          evt_nobuf_o
);
  logic [AW-1:0]    ptr;
  logic [CW-1:0]    desc;
  logic [COL_W-1:0] col;
  logic rd, wr, advance;

  tx_ring_ptr #(.AW(AW), .STRIDE(DESC_B)) u_ptr (
    .clk_i, .rst_ni, .dma_en_i, .base_wr_i, .base_addr_i,
    .advance_i(advance), .wrap_i(desc[B_EOR]), .ptr_o(ptr)
  );

  tx_desc_ctrl #(.AW(AW)) u_ctrl (
    .clk_i, .rst_ni, .dma_en_i,
    .poll_i(poll_demand_i | poll_tick_i),
    .ptr_i(ptr), .rdata_i(mem_rdata_i),
    .seg_ready_i, .tx_done_i, .tx_col_i,
    .rd_o(rd), .wr_o(wr), .addr_o(mem_addr_o),
    .desc_o(desc), .col_o(col), .seg_valid_o,
    .advance_o(advance), .evt_fifo_o, .evt_done_o, .evt_nobuf_o
  );

  tx_desc_wb_fmt u_fmt (.desc_i(desc), .col_i(col), .word_o(mem_wdata_o));

  assign mem_req_o   = rd | wr;
  assign mem_we_o    = wr;
  assign seg_len_o   = desc[LEN_LSB +: LW];
  assign seg_first_o = desc[B_FIRST];
  assign seg_last_o  = desc[B_LAST];

  p_wb_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[B_OWN]);
  p_no_idle_access_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |=> !mem_req_o && !seg_valid_o);
endmodule

// File: tb/tx_desc_fetcher_tb_top.sv
module tx_desc_fetcher_tb_top;
  localparam int AW = 16;
  localparam int NV = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dma_en = 0, base_wr = 0, poll_demand = 0, poll_tick = 0;
  logic [AW-1:0] base_addr = '0;
  logic mem_req, mem_we, seg_valid, seg_first, seg_last;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata = '0;
  logic [10:0] seg_len;
  logic seg_ready = 0, tx_done = 0;
  logic [1:0] tx_col = '0;
  logic evt_fifo, evt_done, evt_nobuf;

  logic [63:0] mem [16];
  int rd_cnt = 0, wr_cnt = 0, fifo_cnt = 0, done_cnt = 0, nobuf_cnt = 0;
  logic [AW-1:0] last_rd = '0, last_wr = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tx_desc_fetcher #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dma_en_i(dma_en), .base_wr_i(base_wr),
    .base_addr_i(base_addr), .poll_demand_i(poll_demand), .poll_tick_i(poll_tick),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .seg_valid_o(seg_valid), .seg_len_o(seg_len), .seg_first_o(seg_first),
    .seg_last_o(seg_last), .seg_ready_i(seg_ready), .tx_done_i(tx_done),
    .tx_col_i(tx_col), .evt_fifo_o(evt_fifo), .evt_done_o(evt_done),
    .evt_nobuf_o(evt_nobuf)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[7:4]] <= mem_wdata; wr_cnt <= wr_cnt + 1; last_wr <= mem_addr;
      end else begin
        mem_rdata <= mem[mem_addr[7:4]]; rd_cnt <= rd_cnt + 1; last_rd <= mem_addr;
      end
    end
    if (evt_fifo)  fifo_cnt  <= fifo_cnt + 1;
    if (evt_done)  done_cnt  <= done_cnt + 1;
    if (evt_nobuf) nobuf_cnt <= nobuf_cnt + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic poll(input bit tick);
    @(negedge clk);
    if (tick) poll_tick = 1; else poll_demand = 1;
    @(negedge clk);
    poll_tick = 0; poll_demand = 0;
  endtask

  task automatic wait_seg(input string req);
    int t = 0;
    while (!seg_valid && t < 50) begin @(negedge clk); t++; end
    chk(req, seg_valid, 1);
  endtask

  task automatic ack();
    seg_ready = 1; @(negedge clk); seg_ready = 0;
  endtask

  function automatic logic [63:0] mk(bit eor, bit dirq, bit firq, bit first, bit last,
                                     int len, logic [7:0] junk);
    logic [63:0] w = '0;
    w[63] = eor; w[62] = dirq; w[61] = firq; w[60] = first; w[59] = last;
    w[42:32] = 11'(len); w[31] = 1'b1; w[7:0] = junk;
    return w;
  endfunction

  // {control word, collision status}
  localparam logic [65:0] VEC [NV] = '{
    {64'h3000_0064_8000_0023, 2'd0},
    {64'h4800_003C_8000_0011, 2'd2},
    {64'hF800_07FF_8000_0003, 2'd1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] ctrl, exp;
    logic [1:0] col;
    int f0, d0, w0, r0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R1 req", mem_req, 0);
    chk("R1 seg", seg_valid, 0);
    chk("R1 evt", {evt_fifo, evt_done, evt_nobuf}, 0);

    for (int i = 0; i < NV; i++) mem[i] = VEC[i][65:2];
    poll(0); cyc(4);
    chk("R2 disabled poll ignored", rd_cnt, 0);

    dma_en = 1;
    poll(0);
    for (int i = 0; i < NV; i++) begin
      ctrl = VEC[i][65:2]; col = VEC[i][1:0];
      wait_seg("R4 seg valid");
      chk("R9 fetch addr", last_rd, 64'(i * 16));
      chk("R4 len", seg_len, ctrl[42:32]);
      chk("R4 first", seg_first, ctrl[60]);
      chk("R4 last", seg_last, ctrl[59]);
      if (i == 0) begin
        r0 = rd_cnt;
        poll(1); cyc(2);
        chk("R2 busy poll ignored", rd_cnt, r0);
        chk("R4 seg held", {seg_valid, seg_len}, {1'b1, ctrl[42:32]});
        chk("R1 base zero", last_rd, 0);
      end
      f0 = fifo_cnt; d0 = done_cnt; w0 = wr_cnt;
      ack(); cyc(1);
      chk("R5 fifo evt", fifo_cnt - f0, ctrl[61]);
      if (ctrl[59]) begin
        cyc(3);
        chk("R6 no early writeback", wr_cnt, w0);
        tx_col = col; tx_done = 1; @(negedge clk); tx_done = 0;
      end
      cyc(3);
      exp = ctrl; exp[31] = 0; exp[1:0] = ctrl[59] ? col : 2'd0;
      chk("R7 writeback word", mem[i], exp);
      chk("R7 writeback addr", last_wr, 64'(i * 16));
      chk("R6 one writeback", wr_cnt - w0, 1);
      chk("R8 done evt", done_cnt - d0, ctrl[62] & ctrl[59]);
    end
    cyc(4);
    chk("R9 wrap to base", last_rd, 0);
    chk("R3 nobuf evt", nobuf_cnt, 1);
    chk("R3 no seg", seg_valid, 0);
    r0 = rd_cnt; cyc(4);
    chk("R3 stays idle", rd_cnt, r0);
    poll(0); cyc(4);
    chk("R3 refetch same", last_rd, 0);
    chk("R3 nobuf again", nobuf_cnt, 2);

    // base write alignment
    mem[4] = mk(0, 1, 0, 1, 1, 8, 8'h00);
    mem[8] = '0;
    @(negedge clk); base_addr = 16'h0047; base_wr = 1;
    @(negedge clk); base_wr = 0;
    poll(1);
    wait_seg("R10 seg after base");
    chk("R10 aligned base", last_rd, 16'h0040);
    ack(); cyc(2);
    // base write in the writeback cycle
    tx_col = 2'd3; tx_done = 1;
    @(negedge clk); tx_done = 0; base_addr = 16'h0080; base_wr = 1;
    @(negedge clk); base_wr = 0;
    cyc(4);
    chk("R10 wb addr kept", last_wr, 16'h0040);
    chk("R10 base wins", last_rd, 16'h0080);
    chk("R10 nobuf at new base", nobuf_cnt, 3);

    // disable mid-walk
    mem[8] = mk(0, 0, 0, 1, 0, 10, 8'h00);
    mem[9] = mk(0, 0, 0, 0, 1, 20, 8'h00);
    poll(0);
    wait_seg("R11 first seg"); ack();
    wait_seg("R11 second seg");
    chk("R11 second len", seg_len, 20);
    w0 = wr_cnt;
    @(negedge clk); dma_en = 0;
    @(negedge clk);
    chk("R11 seg dropped", seg_valid, 0);
    cyc(2); dma_en = 1;
    poll(0); cyc(4);
    chk("R11 rewind to base", last_rd, 16'h0080);
    chk("R11 no writeback", wr_cnt, w0);
    chk("R11 abandoned owned", mem[9][31], 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule